// File: doc/BRIEF.md
# Trapping Integer ALU with Comparisons

This block is a 32-bit integer execution unit with one register stage at its output. Each accepted operation is one of eight kinds: add and subtract in a checked form that flags signed overflow, the same two in a wrapping form that never flags, signed and unsigned set-on-less-than, and logical and arithmetic right shift. The caller presents two operands, an operation code and a strobe. One cycle later the unit presents the result together with either a valid flag or an overflow-exception flag. To get an immediate form of an operation, the caller passes the sign-extended immediate as the second operand.

The output side is a small state machine with three named states:
- `ST_IDLE` means no result is being presented.
- `ST_DONE` means a result is presented and may be written.
- `ST_TRAP` means a checked add or subtract overflowed, so the write must be withheld.

Every state has the same transitions on each clock:
- With the strobe high and no overflow, the machine moves to `ST_DONE`.
- With the strobe high and an overflow, it moves to `ST_TRAP`.
- With the strobe low, it returns to `ST_IDLE`.

The unsigned less-than doubles as a one-step bounds check. A negative index looks like a huge unsigned number, so the single test X < Y (unsigned) also rejects X < 0.

Top module: `trap_alu`

## Requirements
- R1: The op code `op_i` is decoded as follows: 0 checked add, 1 checked subtract, 2 wrapping add, 3 wrapping subtract, 4 signed less-than, 5 unsigned less-than, 6 logical right shift, 7 arithmetic right shift.
- R2: A checked add raises `ovf_o` exactly when the two operands share a sign and the sum's sign differs from it. When the operand signs differ it never raises `ovf_o`. `result_o` always carries the 32-bit wrapped sum.
- R3: A checked subtract raises `ovf_o` exactly when the operands differ in sign and the difference's sign differs from the minuend's sign. `result_o` carries the wrapped difference.
- R4: A wrapping add or subtract returns the modulo-2^32 result and never raises `ovf_o`. No operation other than op 0 and op 1 ever raises `ovf_o`.
- R5: Signed less-than returns 1 in bit 0 with all other bits zero when A < B as two's complement, and 0 otherwise. For A=0xFFFFFFFF and B=0 it returns 1.
- R6: Unsigned less-than compares A and B as unsigned numbers and returns 0 for A=0xFFFFFFFF, B=0. With a non-negative bound Y it returns 1 exactly when 0 <= X < Y, so a negative X returns 0.
- R7: A logical right shift moves A right by the low 5 bits of B and fills with zeros. For example, 0xFFFFFFFB shifted by 2 gives 0x3FFFFFFE.
- R8: An arithmetic right shift fills with A's sign bit. For example, 0xFFFFFFFB shifted by 2 gives 0xFFFFFFFE.
- R9: Outputs change one clock after the strobe. A cycle without the strobe drops both flags on the next clock and leaves `result_o` unchanged.
- R10: While reset is active, `res_valid_o`, `ovf_o` and `result_o` are all zero.
- R11: `res_valid_o` and `ovf_o` are never high together. An overflow suppresses the valid flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 3 | Operation code (R1) |
| opa_i | input | 32 | Operand A / minuend / shifted value |
| opb_i | input | 32 | Operand B / subtrahend / shift amount in low 5 bits |
| result_o | output | 32 | Registered result |
| res_valid_o | output | 1 | Result may be written |
| ovf_o | output | 1 | Overflow exception raised |

## Verification
The hardest cases to reach are the exact signed boundaries, where one unit past 0x7FFFFFFF or 0x80000000 flips the flag. Random operands almost never hit these points. The stimulus therefore aims at them directly, including 0 minus 0x80000000 and mixed-sign pairs that sit at the extremes without overflowing. It also drives a trapping operation immediately followed by a clean one and by an idle cycle, so the machine makes the direct ST_TRAP to ST_DONE and ST_TRAP to ST_IDLE moves. After that, a long pseudo-random stream checks every op code against an independent wide-integer model.

// File: rtl/trap_alu_pkg.sv
package trap_alu_pkg;
    localparam int unsigned OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADD_T  = 3'd0,
        OP_SUB_T  = 3'd1,
        OP_ADD_W  = 3'd2,
        OP_SUB_W  = 3'd3,
        OP_LT_S   = 3'd4,
        OP_LT_U   = 3'd5,
        OP_SHR_L  = 3'd6,
        OP_SHR_A  = 3'd7
    } alu_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DONE = 2'd1,
        ST_TRAP = 2'd2
    } out_state_e;
endpackage

// File: rtl/trap_alu_addsub.sv
module trap_alu_addsub #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         sovf_o
);
    logic [W-1:0] b_eff;

    always_comb begin
        b_eff  = sub_i ? ~b_i : b_i;
        sum_o  = a_i + b_eff + {{(W-1){1'b0}}, sub_i};
        sovf_o = (a_i[W-1] == b_eff[W-1]) && (sum_o[W-1] != a_i[W-1]);
    end

    // Overflow may only appear for like signs (add) or unlike signs (sub)
    always_comb begin
        if (sovf_o && !sub_i)
            assert_add_like_signs_R2: assert (a_i[W-1] == b_i[W-1]);
        if (sovf_o && sub_i)
            assert_sub_unlike_signs_R3: assert (a_i[W-1] != b_i[W-1]);
    end
endmodule

// File: rtl/trap_alu_cmp.sv
module trap_alu_cmp #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic         lt_s_o,
    output logic         lt_u_o
);
    logic sign_mix;

    always_comb begin
        lt_u_o   = (a_i < b_i);
        sign_mix = a_i[W-1] ^ b_i[W-1];
        lt_s_o   = sign_mix ? a_i[W-1] : lt_u_o;
    end

    always_comb begin
        if (a_i == b_i)
            assert_equal_not_less_R5: assert (!lt_s_o && !lt_u_o);
    end
endmodule

// File: rtl/trap_alu_shift.sv
module trap_alu_shift #(
    parameter int unsigned W   = 32,
    parameter int unsigned SHW = $clog2(W)
) (
    input  logic [W-1:0]   a_i,
    input  logic [SHW-1:0] amt_i,
    input  logic           arith_i,
    output logic [W-1:0]   y_o
);
    logic           fill;
    logic [W-1:0]   stg [0:SHW];

    assign fill   = arith_i & a_i[W-1];
    assign stg[0] = a_i;

    for (genvar i = 0; i < SHW; i++) begin : g_stage
        localparam int unsigned SH = 1 << i;
        assign stg[i+1] = amt_i[i] ? {{SH{fill}}, stg[i][W-1:SH]} : stg[i];
    end

    assign y_o = stg[SHW];

    always_comb begin
        if (amt_i == '0)
            assert_zero_shift_identity_R7: assert (y_o == a_i);
    end
endmodule

// File: rtl/trap_alu.sv
module trap_alu
    import trap_alu_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          valid_i,
    input  logic [2:0]    op_i,
    input  logic [W-1:0]  opa_i,
    input  logic [W-1:0]  opb_i,
    output logic [W-1:0]  result_o,
    output logic          res_valid_o,
    output logic          ovf_o
);
    localparam int unsigned SHW = $clog2(W);

    alu_op_e      op_e;
    logic         use_sub;
    logic [W-1:0] sum;
    logic         sovf;
    logic         lt_s, lt_u;
    logic [W-1:0] shr;
    logic [W-1:0] res_d;
    logic         trap_d;
    logic [W-1:0] res_q;
    out_state_e   state_q, state_d;

    assign op_e    = alu_op_e'(op_i);
    assign use_sub = (op_e == OP_SUB_T) || (op_e == OP_SUB_W);

    trap_alu_addsub #(.W(W)) u_addsub (
        .a_i   (opa_i),
        .b_i   (opb_i),
        .sub_i (use_sub),
        .sum_o (sum),
        .sovf_o(sovf)
    );

    trap_alu_cmp #(.W(W)) u_cmp (
        .a_i   (opa_i),
        .b_i   (opb_i),
        .lt_s_o(lt_s),
        .lt_u_o(lt_u)
    );

    trap_alu_shift #(.W(W), .SHW(SHW)) u_shift (
        .a_i    (opa_i),
        .amt_i  (opb_i[SHW-1:0]),
        .arith_i(op_e == OP_SHR_A),
        .y_o    (shr)
    );

    // Result select and exception decision
    always_comb begin
        res_d  = '0;
        trap_d = 1'b0;
        unique case (op_e)
            OP_ADD_T, OP_SUB_T: begin
                res_d  = sum;
                trap_d = sovf;
            end
            OP_ADD_W, OP_SUB_W: res_d = sum;
            OP_LT_S:            res_d = {{(W-1){1'b0}}, lt_s};
            OP_LT_U:            res_d = {{(W-1){1'b0}}, lt_u};
            OP_SHR_L, OP_SHR_A: res_d = shr;
            default:            res_d = '0;
        endcase
    end

    // Next-state logic
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_DONE, ST_TRAP: begin
                if (valid_i) state_d = trap_d ? ST_TRAP : ST_DONE;
                else         state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // Result register
    always_ff @(posedge clk_i) begin
        if (!rst_ni)      res_q <= '0;
        else if (valid_i) res_q <= res_d;
    end

    // Outputs from state
    always_comb begin
        res_valid_o = (state_q == ST_DONE);
        ovf_o       = (state_q == ST_TRAP);
        result_o    = res_q;
    end

    assert_trap_kills_valid_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(res_valid_o && ovf_o));

    assert_idle_drops_flags_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_i |=> (!res_valid_o && !ovf_o));

    assert_idle_holds_result_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_i |=> $stable(result_o));

    assert_wrap_never_traps_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && op_i[2:1] != 2'b00) |=> !ovf_o);

    assert_compare_single_bit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && op_i[2:1] == 2'b10) |=> (result_o[W-1:1] == '0));

    assert_wrap_add_value_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && op_i == 3'd2) |=> (result_o == $past(opa_i + opb_i)));
endmodule

// File: tb/trap_alu_tb_top.sv
`timescale 1ns/1ps
module trap_alu_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [31:0] a = '0, b = '0;
    logic [31:0] result;
    logic        res_valid, ovf;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 1'b0;
    logic [31:0] last_res = '0;

    typedef struct {
        int          due;
        logic [31:0] res;
        logic        vld;
        logic        ovf;
        string       tag;
    } exp_t;
    exp_t q[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    trap_alu dut_i (
        .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op),
        .opa_i(a), .opb_i(b), .result_o(result),
        .res_valid_o(res_valid), .ovf_o(ovf)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic void model(input logic [2:0] o, input logic [31:0] x, input logic [31:0] y,
                                  output logic [31:0] r, output logic v);
        longint s;
        logic [31:0] m;
        int sh;
        v = 1'b0;
        sh = int'(y[4:0]);
        case (o)
            3'd0, 3'd2: begin
                s = longint'($signed(x)) + longint'($signed(y));
                r = s[31:0];
                if (o == 3'd0) v = (s > 64'sd2147483647) || (s < -64'sd2147483648);
            end
            3'd1, 3'd3: begin
                s = longint'($signed(x)) - longint'($signed(y));
                r = s[31:0];
                if (o == 3'd1) v = (s > 64'sd2147483647) || (s < -64'sd2147483648);
            end
            3'd4: r = ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
            3'd5: r = (x < y) ? 32'd1 : 32'd0;
            default: begin
                r = x >> sh;
                m = (sh == 0) ? 32'd0 : ~(32'hFFFF_FFFF >> sh);
                if (o == 3'd7 && x[31]) r = r | m;
            end
        endcase
    endfunction

    task automatic issue(input logic [2:0] o, input logic [31:0] x, input logic [31:0] y, input string tag);
        exp_t e;
        logic [31:0] r;
        logic v;
        @(negedge clk);
        op = o; a = x; b = y; valid = 1'b1;
        model(o, x, y, r, v);
        last_res = r;
        e.due = cyc + 1; e.res = r; e.vld = !v; e.ovf = v; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic idle(input string tag);
        exp_t e;
        @(negedge clk);
        valid = 1'b0; a = 32'hDEAD_BEEF; op = 3'd2;
        e.due = cyc + 1; e.res = last_res; e.vld = 1'b0; e.ovf = 1'b0; e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: pops expected items when their cycle arrives
    always @(posedge clk) begin
        #1;
        while (q.size() > 0 && q[0].due == cyc) begin
            exp_t e;
            e = q.pop_front();
            check({e.tag, " result"}, result, e.res);
            check({e.tag, " valid"}, {31'd0, res_valid}, {31'd0, e.vld});
            check({e.tag, " ovf"}, {31'd0, ovf}, {31'd0, e.ovf});
        end
    end

    initial begin
        logic [31:0] lfsr;
        repeat (3) @(posedge clk);
        #1;
        check("R10 reset valid", {31'd0, res_valid}, 32'd0);
        check("R10 reset ovf", {31'd0, ovf}, 32'd0);
        check("R10 reset result", result, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        issue(3'd0, 32'd5, 32'd7, "R2 add ok");
        issue(3'd0, 32'h7FFF_FFFF, 32'd1, "R2 R11 add pos ovf");
        issue(3'd0, 32'h8000_0000, 32'hFFFF_FFFF, "R2 add neg ovf");
        issue(3'd0, 32'h7FFF_FFFF, 32'h8000_0000, "R2 mixed signs");
        issue(3'd1, 32'h8000_0000, 32'd1, "R3 sub neg ovf");
        idle("R9 idle after trap");
        issue(3'd1, 32'h7FFF_FFFF, 32'hFFFF_FFFF, "R3 sub pos ovf");
        issue(3'd1, 32'd0, 32'h8000_0000, "R3 zero minus min");
        issue(3'd1, 32'd5, 32'd9, "R3 sub ok");
        issue(3'd2, 32'h7FFF_FFFF, 32'd1, "R4 wrap add");
        issue(3'd3, 32'd0, 32'd1, "R4 wrap sub");
        issue(3'd3, 32'h8000_0000, 32'd1, "R4 wrap sub boundary");
        issue(3'd4, 32'hFFFF_FFFF, 32'd0, "R5 slt signed");
        issue(3'd4, 32'd3, 32'd3, "R5 slt equal");
        issue(3'd5, 32'hFFFF_FFFF, 32'd0, "R6 slt unsigned");
        issue(3'd5, 32'd3, 32'd10, "R6 bound in");
        issue(3'd5, 32'd10, 32'd10, "R6 bound edge");
        issue(3'd5, 32'hFFFF_FFFF, 32'd10, "R6 bound negative");
        issue(3'd6, 32'hFFFF_FFFB, 32'd2, "R7 srl");
        issue(3'd6, 32'hFFFF_FFFB, 32'h0000_0022, "R7 srl low bits");
        issue(3'd7, 32'hFFFF_FFFB, 32'd2, "R8 sra");
        issue(3'd7, 32'h8000_0000, 32'd31, "R8 sra full");
        issue(3'd7, 32'h4000_0000, 32'd4, "R8 sra positive");
        idle("R9 idle hold");
        idle("R9 idle hold 2");
        issue(3'd0, 32'h4000_0000, 32'h4000_0000, "R11 trap then idle");
        idle("R9 after trap");

        lfsr = 32'hACE1_1234;
        for (int i = 0; i < 300; i++) begin
            logic [31:0] x, y;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            x = lfsr;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            y = (i % 5 == 0) ? {lfsr[31], 31'h7FFF_FFF0 | lfsr[3:0]} : lfsr;
            if (i % 7 == 3) idle("R9 random idle");
            else issue(3'(i % 8), x, y, "R1 random op");
        end
        idle("R9 drain");
        repeat (4) @(posedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule